// File: doc/BRIEF.md
# Polled Keyboard and Display Port

This block attaches one character input device and one character output device to a shared processor bus. The processor reaches it through ordinary loads and stores. Four word-spaced registers sit in a 16-byte window at a parameterized base address. The registers hold the received character, the character to send, a status word and a control word. The block answers only inside that window, so other slaves can share the same address, data and read/write command lines.

Software polls the status word. A set "character waiting" flag tells it that a received character can be read. A set "display free" flag tells it that a new character can be written. Each data register is a one-character buffer. A store to the output register finishes in one bus cycle, and the slow display drains the character later. On the device side, the block uses a valid/ready pair toward the keyboard and another toward the display. The read data is zero whenever the block is not the target of a read, so an OR can merge it with the read data of other slaves.

Top module: `kbd_disp_port`

## Requirements
- R1: In the cycle after reset is released, the status word reads 0x2 (bit 0 clear, bit 1 set). The received-character, output-character and control registers read 0. `disp_valid` is 0. From the first cycle after reset, `key_ready` is 1.
- R2: The block decodes only the aligned offsets 0x0 (received character), 0x4 (output character), 0x8 (status) and 0xC (control) above `BASE_ADDR`. A read of any other offset inside the 16-byte window returns 0. An access outside the window reads 0, changes no flag and starts no display transfer.
- R3: While `bus_rd` is 0, `bus_rdata` is 0.
- R4: If `key_valid` is 1 while `key_ready` is 1, the block stores `key_char` in the received-character register, and status bit 0 reads 1 from the next cycle. A newer character overwrites an unread one.
- R5: A read at offset 0x0 returns the stored character, zero-extended, in the same cycle. Status bit 0 is then clear from the next cycle. If a new character is accepted in that same cycle, the read still returns the old character, bit 0 stays 1 and the new character is stored.
- R6: A write at offset 0x4 while status bit 1 is 1 latches `bus_wdata[7:0]`. From the next cycle that byte appears on `disp_char` with `disp_valid` at 1, status bit 1 reads 0, and offset 0x4 reads back the byte.
- R7: While `disp_valid` is 1 and `disp_ready` is 0, `disp_valid` and `disp_char` hold their values. A write at offset 0x4 while status bit 1 is 0 is ignored.
- R8: In the cycle after `disp_valid` and `disp_ready` are both 1, `disp_valid` is 0 and status bit 1 reads 1.
- R9: Control bits 1:0 and status bits 3:2 are plain read/write storage with no effect on the device pins. Writes to status bits 1:0 and to offset 0x0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_rd | input | 1 | Read command |
| bus_wr | input | 1 | Write command |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when not selected for a read |
| key_valid | input | 1 | Keyboard offers a character |
| key_char | input | CHAR_W | Offered character |
| key_ready | output | 1 | Port accepts keyboard characters |
| disp_valid | output | 1 | Character waiting for the display |
| disp_char | output | CHAR_W | Character for the display |
| disp_ready | input | 1 | Display takes the character |

## Verification
The hardest case to reach is the cycle in which a keyboard character arrives during the same clock as a processor read of the received-character register. In that cycle the flag's set and clear compete, and the read data must still show the old character. The stimulus drives `key_valid` and the read command on the same falling edge. It then reads the status word and the register again to show that the flag stayed set and the new character was kept. The display side is held busy by keeping `disp_ready` low while a second write is attempted, which proves that a write while busy is dropped.

// File: rtl/kdp_pkg.sv
package kdp_pkg;
  typedef enum logic [1:0] {
    REG_RXCHAR = 2'd0,
    REG_TXCHAR = 2'd1,
    REG_STATE  = 2'd2,
    REG_CFG    = 2'd3
  } kdp_reg_e;

  localparam int unsigned ST_RXFULL  = 0;
  localparam int unsigned ST_TXFREE  = 1;
  localparam int unsigned ST_KEYFLAG = 2;
  localparam int unsigned ST_DSPFLAG = 3;

  localparam int unsigned CFG_KEYON = 0;
  localparam int unsigned CFG_DSPON = 1;

  localparam int unsigned WIN_LSB = 4;
endpackage

// File: rtl/kdp_decode.sv
module kdp_decode
  import kdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_hit,
  output kdp_reg_e          which,
  output logic              take_rx,
  output logic              put_tx,
  output logic              put_state,
  output logic              put_cfg
);
  logic in_window;
  logic aligned;
  logic hit;

  assign in_window = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign aligned   = (addr[1:0] == 2'b00);
  assign hit       = in_window && aligned;
  assign which     = kdp_reg_e'(addr[WIN_LSB-1:2]);

  assign rd_hit    = hit && rd;
  assign take_rx   = rd_hit && (which == REG_RXCHAR);
  assign put_tx    = hit && wr && (which == REG_TXCHAR);
  assign put_state = hit && wr && (which == REG_STATE);
  assign put_cfg   = hit && wr && (which == REG_CFG);
endmodule

// File: rtl/kdp_rx.sv
module kdp_rx #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_char,
  input  logic              take,
  output logic              key_ready,
  output logic [CHAR_W-1:0] held,
  output logic              full
);
  logic accept;
  assign accept = key_valid && key_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_ready <= 1'b0;
      held      <= '0;
      full      <= 1'b0;
    end else begin
      key_ready <= 1'b1;
      if (accept) begin
        held <= key_char;
        full <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    accept |=> full && (held == $past(key_char))); // R4
  AST_RX_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (take && !accept) |=> !full); // R5
  AST_RX_KEEP_ON_RACE: assert property (@(posedge clk) disable iff (rst)
    (take && accept) |=> full); // R5
endmodule

// File: rtl/kdp_tx.sv
module kdp_tx #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              put,
  input  logic [CHAR_W-1:0] put_char,
  input  logic              disp_ready,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  output logic              free
);
  logic done;
  assign done = disp_valid && disp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_char  <= '0;
      free       <= 1'b1;
    end else if (done) begin
      disp_valid <= 1'b0;
      free       <= 1'b1;
    end else if (put && free) begin
      disp_char  <= put_char;
      disp_valid <= 1'b1;
      free       <= 1'b0;
    end
  end

  AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
    (put && free && !disp_valid) |=> disp_valid && !free && (disp_char == $past(put_char))); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready) |=> disp_valid && $stable(disp_char)); // R7
  AST_TX_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !disp_valid && free); // R8
endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
  import kdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_char,
  output logic              key_ready,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  input  logic              disp_ready
);
  localparam int unsigned PAD_CHAR = DATA_W - CHAR_W;

  logic              rd_hit;
  kdp_reg_e          which;
  logic              take_rx, put_tx, put_state, put_cfg;
  logic [CHAR_W-1:0] rx_held;
  logic              rx_full, tx_free;
  logic              key_flag, dsp_flag, key_on, dsp_on;
  logic [DATA_W-1:0] state_word, cfg_word;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:CHAR_W];

  kdp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .rd_hit(rd_hit), .which(which), .take_rx(take_rx),
    .put_tx(put_tx), .put_state(put_state), .put_cfg(put_cfg)
  );

  kdp_rx #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_char(key_char),
    .take(take_rx), .key_ready(key_ready), .held(rx_held), .full(rx_full)
  );

  kdp_tx #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst(rst), .put(put_tx), .put_char(bus_wdata[CHAR_W-1:0]),
    .disp_ready(disp_ready), .disp_valid(disp_valid), .disp_char(disp_char),
    .free(tx_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      key_flag <= 1'b0;
      dsp_flag <= 1'b0;
      key_on   <= 1'b0;
      dsp_on   <= 1'b0;
    end else begin
      if (put_state) begin
        key_flag <= bus_wdata[ST_KEYFLAG];
        dsp_flag <= bus_wdata[ST_DSPFLAG];
      end
      if (put_cfg) begin
        key_on <= bus_wdata[CFG_KEYON];
        dsp_on <= bus_wdata[CFG_DSPON];
      end
    end
  end

  always_comb begin
    state_word = '0;
    state_word[ST_RXFULL]  = rx_full;
    state_word[ST_TXFREE]  = tx_free;
    state_word[ST_KEYFLAG] = key_flag;
    state_word[ST_DSPFLAG] = dsp_flag;
    cfg_word = '0;
    cfg_word[CFG_KEYON] = key_on;
    cfg_word[CFG_DSPON] = dsp_on;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (which)
        REG_RXCHAR: bus_rdata = {{PAD_CHAR{1'b0}}, rx_held};
        REG_TXCHAR: bus_rdata = {{PAD_CHAR{1'b0}}, disp_char};
        REG_STATE:  bus_rdata = state_word;
        default:    bus_rdata = cfg_word;
      endcase
    end
  end

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |-> (bus_rdata == '0)); // R3
  AST_FREE_MATCHES_VALID: assert property (@(posedge clk) disable iff (rst)
    tx_free == !disp_valid); // R8
  AST_CFG_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(key_on) && $stable(dsp_on) && $stable(key_flag)); // R9
endmodule

// File: tb/kbd_disp_port_test.sv
module kbd_disp_port_test;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 8;
  localparam logic [AW-1:0] BASE = 16'h0400;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } rd_item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          key_valid = 1'b0;
  logic [CW-1:0] key_char = '0;
  logic          key_ready, disp_valid;
  logic [CW-1:0] disp_char;
  logic          disp_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  rd_item_t exp_q[$];

  always #5 clk = ~clk;

  kbd_disp_port #(.ADDR_W(AW), .DATA_W(DW), .CHAR_W(CW), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_valid(key_valid),
    .key_char(key_char), .key_ready(key_ready), .disp_valid(disp_valid),
    .disp_char(disp_char), .disp_ready(disp_ready)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        chk("monitor: unexpected read", bus_rdata, '0);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    exp_q.push_back('{exp, tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic key_send(input logic [CW-1:0] c);
    @(negedge clk);
    key_valid = 1'b1;
    key_char = c;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 key_ready", {31'b0, key_ready}, 1);
    chk("R1 disp_valid", {31'b0, disp_valid}, 0);
    bus_read(BASE + 16'h8, 32'h2, "R1 status");
    bus_read(BASE + 16'h0, 32'h0, "R1 rxchar");
    bus_read(BASE + 16'h4, 32'h0, "R1 txchar");
    bus_read(BASE + 16'hC, 32'h0, "R1 cfg");

    @(negedge clk);
    bus_addr = BASE + 16'h8;
    #2;
    chk("R3 rdata idle", bus_rdata, 0);

    key_send(8'h41);
    bus_read(BASE + 16'h8, 32'h3, "R4 flag set");
    bus_read(BASE + 16'h0, 32'h41, "R5 read char");
    bus_read(BASE + 16'h8, 32'h2, "R5 flag cleared");

    key_send(8'h11);
    key_send(8'h22);
    bus_read(BASE + 16'h0, 32'h22, "R4 overwrite");

    key_send(8'h33);
    bus_read(BASE + 16'h20, 32'h0, "R2 outside window");
    bus_read(BASE + 16'h2, 32'h0, "R2 unaligned offset");
    bus_read(BASE + 16'h8, 32'h3, "R2 flag untouched");
    bus_write(BASE + 16'h0, 32'h77);
    bus_read(BASE + 16'h8, 32'h3, "R9 rx write ignored flag");

    @(negedge clk);
    key_valid = 1'b1;
    key_char = 8'h44;
    bus_addr = BASE + 16'h0;
    bus_rd = 1'b1;
    exp_q.push_back('{32'h33, "R5 race old char"});
    @(negedge clk);
    key_valid = 1'b0;
    bus_rd = 1'b0;
    bus_read(BASE + 16'h8, 32'h3, "R5 race flag kept");
    bus_read(BASE + 16'h0, 32'h44, "R5 race new char");
    bus_read(BASE + 16'h8, 32'h2, "R5 flag cleared after race");

    bus_write(BASE + 16'h24, 32'hAB);
    #1;
    chk("R2 outside write no transfer", {31'b0, disp_valid}, 0);

    bus_write(BASE + 16'h4, 32'h1234_5658);
    #1;
    chk("R6 disp_valid", {31'b0, disp_valid}, 1);
    chk("R6 disp_char", {24'b0, disp_char}, 32'h58);
    bus_read(BASE + 16'h8, 32'h0, "R6 free cleared");
    bus_read(BASE + 16'h4, 32'h58, "R6 readback");
    bus_write(BASE + 16'h4, 32'h99);
    #1;
    chk("R7 busy write ignored", {24'b0, disp_char}, 32'h58);
    chk("R7 valid held", {31'b0, disp_valid}, 1);

    @(negedge clk);
    disp_ready = 1'b1;
    @(negedge clk);
    disp_ready = 1'b0;
    #1;
    chk("R8 valid dropped", {31'b0, disp_valid}, 0);
    bus_read(BASE + 16'h8, 32'h2, "R8 free again");

    bus_write(BASE + 16'hC, 32'hFF);
    bus_read(BASE + 16'hC, 32'h3, "R9 cfg bits");
    bus_write(BASE + 16'h8, 32'hFF);
    bus_read(BASE + 16'h8, 32'hE, "R9 status storage");
    #1;
    chk("R9 no pin effect valid", {31'b0, disp_valid}, 0);
    chk("R9 no pin effect ready", {31'b0, key_ready}, 1);

    repeat (3) @(negedge clk);
    chk("queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule